// File: doc/BRIEF.md
# Dual-Port Duplicated Tag Lookup

This block decides, for two data-cache accesses at once, whether each one hits and in which way. The cache it serves is two-way set associative, indexed with virtual address bits 14 down to 6 and tagged with the 28-bit physical frame number (physical bits 39 to 12, with 4 KB pages). The set can be selected before address translation finishes. Each access port has its own full copy of the tag and valid storage and its own pair of comparators, so the two lookups never compete for a read port.

A single update port installs a tag (fill) or clears a valid bit (invalidate). Every update is written into both copies on the same clock edge, so the copies never diverge. Lookups are combinational on the stored state: an update becomes visible on the cycle after it is presented, and a lookup in the same cycle sees the old contents.

Top module: `dp_tag_lookup`

## Requirements
- R1: Each port selects its set from bits [14:6] of its virtual address; all other virtual address bits have no effect on the result.
- R2: A port reports hit in the same cycle when, in its selected set, a way has its valid bit set and its stored 28-bit tag equals the frame number presented on that port.
- R3: The way output is one-hot, bit 0 meaning way 0 and bit 1 meaning way 1, and is 2'b00 on a miss.
- R4: When both ways of the selected set match, the port raises its multi-match error, reports hit, and reports way 2'b01.
- R5: The two ports look up independently in the same cycle, whether they address the same set or different sets.
- R6: A fill (update valid high, invalidate low) writes the tag and sets the valid bit of the given set and way in both copies, visible to both ports from the next cycle.
- R7: A lookup in the same cycle as an update to its set returns the contents from before that update.
- R8: An invalidate (update valid high, invalidate high) clears the valid bit of the given set and way in both copies from the next cycle.
- R9: Reset clears every valid bit, so every lookup misses until a fill.
- R10: With update valid low, the update set, way and tag inputs change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_valid | input | 1 | Apply an update this cycle |
| upd_inv | input | 1 | 1 = invalidate, 0 = fill |
| upd_set | input | 9 | Set to update |
| upd_way | input | 1 | Way to update |
| upd_tag | input | 28 | Frame number written on a fill |
| a_vaddr | input | 48 | Port A virtual address |
| a_pfn | input | 28 | Port A translated frame number |
| b_vaddr | input | 48 | Port B virtual address |
| b_pfn | input | 28 | Port B translated frame number |
| a_hit | output | 1 | Port A hit |
| a_way | output | 2 | Port A one-hot hit way |
| a_multi | output | 1 | Port A both ways matched |
| b_hit | output | 1 | Port B hit |
| b_way | output | 2 | Port B one-hot hit way |
| b_multi | output | 1 | Port B both ways matched |

## Verification
Lookup results are combinational, so they are due in the same cycle as the address and frame number, while an update's effect is due one clock edge later. The bench drives every input on the falling edge, samples the outputs one nanosecond later and before the next rising edge, and so each vector checks the pre-update state; the following vector checks the post-update state. Same-cycle fill and lookup to one set is thereby checked for old contents, and the next cycle for the new ones.

// File: rtl/dp_tag_lookup.sv
module dp_tag_lookup #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 40,
  parameter int PG_BITS = 12,
  parameter int IDX_LO = 6,
  parameter int IDX_HI = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_valid,
  input  logic                    upd_inv,
  input  logic [IDX_HI-IDX_LO:0]  upd_set,
  input  logic                    upd_way,
  input  logic [PA_W-PG_BITS-1:0] upd_tag,
  input  logic [VA_W-1:0]         a_vaddr,
  input  logic [PA_W-PG_BITS-1:0] a_pfn,
  input  logic [VA_W-1:0]         b_vaddr,
  input  logic [PA_W-PG_BITS-1:0] b_pfn,
  output logic                    a_hit,
  output logic [1:0]              a_way,
  output logic                    a_multi,
  output logic                    b_hit,
  output logic [1:0]              b_way,
  output logic                    b_multi
);
  localparam int TAG_W = PA_W - PG_BITS;
  localparam int IDX_W = IDX_HI - IDX_LO + 1;
  localparam int SETS  = 1 << IDX_W;
  localparam int NPORT = 2;
  localparam int WAYS  = 2;

  logic [IDX_W-1:0] idx   [NPORT];
  logic [TAG_W-1:0] pfn   [NPORT];
  logic [WAYS-1:0]  match [NPORT];
  logic [1:0]       way_v [NPORT];

  assign idx[0] = a_vaddr[IDX_HI:IDX_LO];
  assign idx[1] = b_vaddr[IDX_HI:IDX_LO];
  assign pfn[0] = a_pfn;
  assign pfn[1] = b_pfn;

  for (genvar p = 0; p < NPORT; p++) begin : g_copy
    logic [SETS-1:0]  vld_q [WAYS];
    logic [TAG_W-1:0] tag_q [WAYS][SETS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)
          vld_q[w] <= '0;
        else if (upd_valid && upd_way == w[0])
          vld_q[w][upd_set] <= !upd_inv;

      always_ff @(posedge clk)
        if (upd_valid && !upd_inv && upd_way == w[0])
          tag_q[w][upd_set] <= upd_tag;

      assign match[p][w] = vld_q[w][idx[p]] && (tag_q[w][idx[p]] == pfn[p]);
    end

    assign way_v[p] = match[p][0] ? 2'b01 : {match[p][1], 1'b0};
  end

  assign a_hit   = |match[0];
  assign a_way   = way_v[0];
  assign a_multi = &match[0];
  assign b_hit   = |match[1];
  assign b_way   = way_v[1];
  assign b_multi = &match[1];

  AST_WAY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(a_way) && $onehot0(b_way) && (a_hit == (a_way != 2'b00)) && (b_hit == (b_way != 2'b00))); // R3
  AST_MULTI_WAY0: assert property (@(posedge clk) disable iff (!rst_n)
    (a_multi |-> (a_hit && a_way == 2'b01)) and (b_multi |-> (b_hit && b_way == 2'b01))); // R4
  AST_COPIES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    (idx[0] == idx[1] && a_pfn == b_pfn) |-> (a_way == b_way && a_multi == b_multi)); // R6
  AST_FILL_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_inv) |=> (((idx[0] == $past(upd_set)) && (a_pfn == $past(upd_tag))) -> a_hit)); // R6
  AST_INV_GONE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_inv) |=> ((idx[1] == $past(upd_set)) -> !b_way[$past(upd_way)])); // R8
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!a_hit && !b_hit)); // R9
endmodule

// File: tb/dp_tag_lookup_bench.sv
module dp_tag_lookup_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        upd_valid = 1'b0, upd_inv = 1'b0, upd_way = 1'b0;
  logic [8:0]  upd_set = '0;
  logic [27:0] upd_tag = '0, a_pfn = '0, b_pfn = '0;
  logic [47:0] a_vaddr = '0, b_vaddr = '0;
  logic        a_hit, a_multi, b_hit, b_multi;
  logic [1:0]  a_way, b_way;

  dp_tag_lookup u_dp_tag_lookup (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_inv(upd_inv), .upd_set(upd_set),
    .upd_way(upd_way), .upd_tag(upd_tag),
    .a_vaddr(a_vaddr), .a_pfn(a_pfn), .b_vaddr(b_vaddr), .b_pfn(b_pfn),
    .a_hit(a_hit), .a_way(a_way), .a_multi(a_multi),
    .b_hit(b_hit), .b_way(b_way), .b_multi(b_multi)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  localparam logic [27:0] T1 = 28'h0ABCDEF;
  localparam logic [27:0] T2 = 28'h1234567;
  localparam logic [27:0] T3 = 28'hFFFFFFF;

  typedef struct packed {
    logic [1:0]  op;     // 0 none, 1 fill, 2 invalidate
    logic [8:0]  uset;
    logic        uway;
    logic [27:0] utag;
    logic [8:0]  aset;
    logic [27:0] atag;
    logic [8:0]  bset;
    logic [27:0] btag;
    logic [2:0]  aexp;   // {multi, way}
    logic [2:0]  bexp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 9'd5,   1'b0, T1, 9'd5,   T1, 9'd5,   T1, 3'b000, 3'b000}, // R7 fill not yet seen
    '{2'd1, 9'd5,   1'b1, T2, 9'd5,   T1, 9'd5,   T2, 3'b001, 3'b000}, // R6 R7
    '{2'd0, 9'd5,   1'b0, T3, 9'd5,   T2, 9'd5,   T1, 3'b010, 3'b001}, // R5 R6, idle update fields
    '{2'd1, 9'd300, 1'b1, T3, 9'd300, T3, 9'd5,   T3, 3'b000, 3'b000}, // R10 R2
    '{2'd0, 9'd0,   1'b0, 28'd0, 9'd300, T3, 9'd301, T3, 3'b010, 3'b000}, // R1 R5
    '{2'd2, 9'd5,   1'b0, 28'd0, 9'd5,   T1, 9'd300, T3, 3'b001, 3'b010}, // R7 invalidate
    '{2'd0, 9'd0,   1'b0, 28'd0, 9'd5,   T1, 9'd5,   T2, 3'b000, 3'b010}, // R8
    '{2'd1, 9'd5,   1'b0, T2, 9'd5,   T2, 9'd5,   T2, 3'b010, 3'b010}, // duplicate fill
    '{2'd0, 9'd0,   1'b0, 28'd0, 9'd5,   T2, 9'd5,   T2, 3'b101, 3'b101}, // R4
    '{2'd1, 9'd511, 1'b0, T3, 9'd511, T3, 9'd0,   T3, 3'b000, 3'b000}, // top set
    '{2'd0, 9'd0,   1'b0, 28'd0, 9'd511, T3, 9'd0,   T3, 3'b001, 3'b000}  // R1 R6
  };

  function automatic logic [47:0] mk_va(input logic [32:0] hi, input logic [8:0] s, input logic [5:0] lo);
    return {hi, s, lo};
  endfunction

  task automatic chk(input string req, input int vn, input logic [2:0] act, input logic [2:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s step %0d: actual %b expected %b", req, vn, act, exp);
    end
  endtask

  task automatic check_ports(input int vn, input logic [2:0] ea, input logic [2:0] eb);
    chk("R2 hit A", vn, {2'b00, a_hit}, {2'b00, ea[1:0] != 2'b00});
    chk("R3 way A", vn, {1'b0, a_way}, {1'b0, ea[1:0]});
    chk("R4 multi A", vn, {2'b00, a_multi}, {2'b00, ea[2]});
    chk("R2 hit B", vn, {2'b00, b_hit}, {2'b00, eb[1:0] != 2'b00});
    chk("R3 way B", vn, {1'b0, b_way}, {1'b0, eb[1:0]});
    chk("R4 multi B", vn, {2'b00, b_multi}, {2'b00, eb[2]});
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    a_vaddr = mk_va(33'h0_0000_0000, 9'd0, 6'd0);
    b_vaddr = mk_va(33'h1_FFFF_FFFF, 9'd511, 6'h3F);
    #1;
    check_ports(-1, 3'b000, 3'b000); // R9 during reset
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      upd_valid = VEC[i].op != 2'd0;
      upd_inv   = VEC[i].op == 2'd2;
      upd_set   = VEC[i].uset;
      upd_way   = VEC[i].uway;
      upd_tag   = VEC[i].utag;
      a_vaddr   = mk_va(33'h1_2345_6789, VEC[i].aset, 6'h2A);
      a_pfn     = VEC[i].atag;
      b_vaddr   = mk_va(33'h0_F0F0_F0F0, VEC[i].bset, 6'h15);
      b_pfn     = VEC[i].btag;
      #1;
      check_ports(i, VEC[i].aexp, VEC[i].bexp);
    end
    @(negedge clk);
    upd_valid = 1'b0;
    // R1: different upper and lower bits, same set 300
    a_vaddr = mk_va(33'h0_0000_0001, 9'd300, 6'h00);
    a_pfn = T3;
    b_vaddr = mk_va(33'h1_8000_0000, 9'd511, 6'h3F);
    b_pfn = T3;
    #1;
    check_ports(100, 3'b010, 3'b001);
    // R9: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_ports(101, 3'b000, 3'b000);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule